// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator and Interrupt Control

This block watches the running clock/calendar of a real-time clock and compares it against a bank of alarm registers that software programs over a simple register bus. Each alarm field (seconds, minutes, hours, day of week, day of month, month) has its own enable. A 16-bit year alarm has a separate enable register. Only the enabled fields take part in the compare. When the calendar time starts to equal the enabled alarm fields, the block sets a sticky alarm flag. Software clears that flag by writing 0 to it.

An 8-bit control register holds the alarm flag and two interrupt enables. One enable gates the alarm flag onto the alarm interrupt request. The other gates a carry flag, which the counter chain supplies, onto the carry interrupt request. Both requests are level signals. The time counters, the prescaler and the carry-flag logic sit outside this block and drive its inputs.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, every alarm register reads 0x00, and both interrupt requests are low.
- R2: The control register bit positions are fixed: bit 4 is the carry interrupt enable, bit 3 is the alarm interrupt enable and bit 0 is the alarm flag. Bits 7, 6, 5, 2 and 1 always read 0, and writes to them have no effect. For example, writing 0xFF with the flag clear reads back 0x18.
- R3: The alarm registers have this address map: address 1 is seconds, 2 is minutes, 3 is hours, 4 is day of week, 5 is day of month and 6 is month. In each, bit 7 is the field enable and bits 6:0 hold the BCD compare value. Address 7 is the low year byte, 8 is the high year byte, and bit 0 of address 9 is the year-alarm enable. Each of these reads back what was written, except that address 9 returns only bit 0.
- R4: The compare uses only the fields whose enable is 1. When the value of every enabled field (bits 6:0) equals the matching time input, the alarm flag sets at the next clock edge. Fields that are not enabled do not affect the result.
- R5: The 16-bit year alarm takes part in the compare only when the year-alarm enable is 1. When it does, it must equal the year input.
- R6: Writing the control register with bit 0 = 0 clears the alarm flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R7: The alarm interrupt request is high exactly while the alarm flag is 1 and the alarm interrupt enable is 1.
- R8: The carry interrupt request is high exactly while the carry flag input is 1 and the carry interrupt enable is 1.
- R9: When no field enable and no year-alarm enable is set, no match occurs, and the alarm flag never sets.
- R10: When a new match and a write of 0 to the flag fall in the same cycle, the flag ends up set.
- R11: The flag sets once each time the time enters a match. If software clears the flag while the time still matches, the flag stays clear until the match ends and begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address for read and write |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the addressed register (combinational) |
| timeNow | input | 48 | BCD time fields, 8 bits each. Field i sits at bits 8i+7:8i, in the order sec, min, hour, dow, day, month |
| yearNow | input | 16 | BCD current year |
| carryFlag | input | 1 | Carry flag from the counter chain |
| alarmIrq | output | 1 | Alarm interrupt request (level) |
| carryIrq | output | 1 | Carry interrupt request (level) |

## Verification
The hardest state to reach from the ports is a cycle in which a new match and a software clear land on the same clock edge. To get there, the bench first holds the time away from the alarm so that the match ends. Then, on one falling edge, it moves the time onto the alarm and presents a clear-write at the same moment. The second hard state is a clear issued while the time still matches. The bench reaches it by writing 0 to the flag after a match has set it, leaving the time where it is. It then checks that the request stays low, and that it returns only after the time leaves the alarm and comes back.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int FIELD_COUNT = 6;
  localparam int YEAR_W      = 16;
  localparam int CMP_W       = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_FIELD0  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_YEAR_LO = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_YEAR_HI = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_YEAR_EN = 4'd9;

  localparam int BIT_CIE = 4;
  localparam int BIT_AIE = 3;
  localparam int BIT_AF  = 0;

  typedef struct packed {
    logic [FIELD_COUNT-1:0] wrField;
    logic                   wrYearLo;
    logic                   wrYearHi;
    logic                   wrYearEn;
    logic [DATA_W-1:0]      data;
  } alarm_strobe_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] alarmRdData,
  input  logic              matchRise,
  input  logic              carryFlag,
  output alarm_strobe_t     strobe,
  output logic [DATA_W-1:0] busRdData,
  output logic              afFlag,
  output logic              aieBit,
  output logic              cieBit,
  output logic              alarmIrq,
  output logic              carryIrq
);
  logic wrCtrl;

  always_comb begin
    strobe          = '0;
    strobe.data     = busWrData;
    strobe.wrYearLo = busWrEn && (busAddr == ADDR_YEAR_LO);
    strobe.wrYearHi = busWrEn && (busAddr == ADDR_YEAR_HI);
    strobe.wrYearEn = busWrEn && (busAddr == ADDR_YEAR_EN);
    for (int i = 0; i < FIELD_COUNT; i++) begin
      strobe.wrField[i] = busWrEn && (busAddr == ADDR_FIELD0 + ADDR_W'(i));
    end
  end

  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      afFlag <= 1'b0;
      aieBit <= 1'b0;
      cieBit <= 1'b0;
    end else begin
      if (wrCtrl) begin
        aieBit <= busWrData[BIT_AIE];
        cieBit <= busWrData[BIT_CIE];
      end
      if (matchRise) begin
        afFlag <= 1'b1;
      end else if (wrCtrl && !busWrData[BIT_AF]) begin
        afFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    if (busAddr == ADDR_CTRL) begin
      busRdData          = '0;
      busRdData[BIT_CIE] = cieBit;
      busRdData[BIT_AIE] = aieBit;
      busRdData[BIT_AF]  = afFlag;
    end else begin
      busRdData = alarmRdData;
    end
  end

  assign alarmIrq = afFlag & aieBit;
  assign carryIrq = carryFlag & cieBit;
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  alarm_strobe_t                 strobe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [FIELD_COUNT*DATA_W-1:0] timeNow,
  input  logic [YEAR_W-1:0]             yearNow,
  output logic [DATA_W-1:0]             alarmRdData,
  output logic                          matchRise
);
  logic [DATA_W-1:0]      fieldReg [FIELD_COUNT];
  logic [FIELD_COUNT-1:0] fieldOk;
  logic [FIELD_COUNT-1:0] fieldEn;
  logic [YEAR_W-1:0]      yearReg;
  logic                   yearEn;
  logic                   anyEn;
  logic                   matchNow;
  logic                   matchPrev;

  for (genvar g = 0; g < FIELD_COUNT; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN) fieldReg[g] <= '0;
      else if (strobe.wrField[g]) fieldReg[g] <= strobe.data;
    end
    assign fieldEn[g] = fieldReg[g][DATA_W-1];
    assign fieldOk[g] = !fieldEn[g] ||
                        (fieldReg[g][CMP_W-1:0] == timeNow[g*DATA_W +: CMP_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yearReg <= '0;
      yearEn  <= 1'b0;
    end else begin
      if (strobe.wrYearLo) yearReg[DATA_W-1:0]      <= strobe.data;
      if (strobe.wrYearHi) yearReg[YEAR_W-1:DATA_W] <= strobe.data;
      if (strobe.wrYearEn) yearEn                   <= strobe.data[0];
    end
  end

  assign anyEn    = (|fieldEn) | yearEn;
  assign matchNow = anyEn && (&fieldOk) && (!yearEn || (yearReg == yearNow));

  always_ff @(posedge clk) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= matchNow;
  end

  assign matchRise = matchNow && !matchPrev;

  always_comb begin
    alarmRdData = '0;
    for (int i = 0; i < FIELD_COUNT; i++) begin
      if (busAddr == ADDR_FIELD0 + ADDR_W'(i)) alarmRdData = fieldReg[i];
    end
    if (busAddr == ADDR_YEAR_LO) alarmRdData = yearReg[DATA_W-1:0];
    if (busAddr == ADDR_YEAR_HI) alarmRdData = yearReg[YEAR_W-1:DATA_W];
    if (busAddr == ADDR_YEAR_EN) alarmRdData = {{(DATA_W-1){1'b0}}, yearEn};
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  input  logic [FIELD_COUNT*DATA_W-1:0] timeNow,
  input  logic [YEAR_W-1:0]             yearNow,
  input  logic                          carryFlag,
  output logic                          alarmIrq,
  output logic                          carryIrq
);
  alarm_strobe_t     strobe;
  logic [DATA_W-1:0] alarmRdData;
  logic              matchRise;
  logic              afFlag;
  logic              aieBit;
  logic              cieBit;

  rtc_alarm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .alarmRdData(alarmRdData),
    .matchRise  (matchRise),
    .carryFlag  (carryFlag),
    .strobe     (strobe),
    .busRdData  (busRdData),
    .afFlag     (afFlag),
    .aieBit     (aieBit),
    .cieBit     (cieBit),
    .alarmIrq   (alarmIrq),
    .carryIrq   (carryIrq)
  );

  rtc_alarm_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busAddr    (busAddr),
    .timeNow    (timeNow),
    .yearNow    (yearNow),
    .alarmRdData(alarmRdData),
    .matchRise  (matchRise)
  );
endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              carryFlag,
  input logic              alarmIrq,
  input logic              carryIrq,
  input logic              afFlag,
  input logic              aieBit,
  input logic              matchRise
);
  // R2: reserved control bits never read as 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> ((busRdData & 8'hE6) == 8'h00));

  // R6: a write of 0 with no new match clears the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTRL && !busWrData[BIT_AF] && !matchRise) |=> !afFlag);

  // R6: a write of 1 leaves the flag as it was
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTRL && busWrData[BIT_AF] && !matchRise) |=> $stable(afFlag));

  // R10: a new match always leaves the flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    matchRise |=> afFlag);

  // R11: the flag only rises on a match entry
  a_r11_rise_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(afFlag) |-> $past(matchRise));

  // R7: alarm request needs both flag and enable
  a_r7_alarm_req: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> (afFlag && aieBit));

  // R8: carry request never without the carry flag
  a_r8_carry_req: assert property (@(posedge clk) disable iff (!rstN)
    carryIrq |-> carryFlag);
endmodule

bind rtc_alarm_irq rtc_alarm_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .carryFlag(carryFlag),
  .alarmIrq (alarmIrq),
  .carryIrq (carryIrq),
  .afFlag   (afFlag),
  .aieBit   (aieBit),
  .matchRise(matchRise)
);

// File: tb/test_rtc_alarm_irq.sv
`timescale 1ns/1ps
module test_rtc_alarm_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [47:0] timeNow = {6{8'h7F}};
  logic [15:0] yearNow = 16'hFFFF;
  logic        carryFlag = 1'b0;
  logic        alarmIrq;
  logic        carryIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .timeNow(timeNow),
    .yearNow(yearNow), .carryFlag(carryFlag), .alarmIrq(alarmIrq),
    .carryIrq(carryIrq)
  );

  typedef struct packed {
    logic [7:0]  aSec;
    logic [7:0]  aMin;
    logic [7:0]  aHour;
    logic        yen;
    logic [15:0] aYear;
    logic [7:0]  nSec;
    logic [7:0]  nMin;
    logic [7:0]  nHour;
    logic [15:0] nYear;
    logic        expIrq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h85, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h05, 8'h00, 8'h00, 16'h2000, 1'b1}, // R4
    '{8'h85, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h06, 8'h00, 8'h00, 16'h2000, 1'b0}, // R4
    '{8'hB0, 8'h95, 8'h00, 1'b0, 16'h0000, 8'h30, 8'h15, 8'h00, 16'h2000, 1'b1}, // R4
    '{8'hB0, 8'h95, 8'h00, 1'b0, 16'h0000, 8'h30, 8'h16, 8'h00, 16'h2000, 1'b0}, // R4
    '{8'h30, 8'h95, 8'h00, 1'b0, 16'h0000, 8'h45, 8'h15, 8'h00, 16'h2000, 1'b1}, // R4 disabled ignored
    '{8'h00, 8'h00, 8'h00, 1'b0, 16'h2024, 8'h00, 8'h00, 8'h00, 16'h2024, 1'b0}, // R9
    '{8'h00, 8'h00, 8'h00, 1'b1, 16'h2024, 8'h11, 8'h22, 8'h05, 16'h2024, 1'b1}, // R5
    '{8'h00, 8'h00, 8'h00, 1'b1, 16'h2024, 8'h11, 8'h22, 8'h05, 16'h2025, 1'b0}, // R5
    '{8'h00, 8'h00, 8'h92, 1'b0, 16'h2024, 8'h00, 8'h00, 8'h12, 16'h2099, 1'b1}, // R5 year off
    '{8'h00, 8'h00, 8'hA3, 1'b1, 16'h1999, 8'h00, 8'h00, 8'h23, 16'h1999, 1'b1}  // R5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic neutral();
    @(negedge clk);
    timeNow = {6{8'h7F}}; yearNow = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle(input logic [47:0] t, input logic [15:0] y);
    @(negedge clk);
    timeNow = t; yearNow = y;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(4'd0, r); check("R1 ctrl", {8'h0, r}, 16'h0000);
    rd(4'd1, r); check("R1 sec alarm", {8'h0, r}, 16'h0000);
    rd(4'd9, r); check("R1 year enable", {8'h0, r}, 16'h0000);
    check("R1 irqs", {14'h0, alarmIrq, carryIrq}, 16'h0000);

    // R2: reserved bits, flag write 1 keeps 0
    wr(4'd0, 8'hFF);
    rd(4'd0, r); check("R2 ctrl readback", {8'h0, r}, 16'h0018);

    // R8: carry request
    wr(4'd0, 8'h00);
    @(negedge clk); carryFlag = 1'b1; #1;
    check("R8 carry gated off", {15'h0, carryIrq}, 16'h0000);
    wr(4'd0, 8'h10); #1;
    check("R8 carry on", {15'h0, carryIrq}, 16'h0001);
    @(negedge clk); carryFlag = 1'b0; #1;
    check("R8 carry flag low", {15'h0, carryIrq}, 16'h0000);

    // R3: register readback
    wr(4'd5, 8'h9A); rd(4'd5, r); check("R3 day reg", {8'h0, r}, 16'h009A);
    wr(4'd7, 8'h34); rd(4'd7, r); check("R3 year lo", {8'h0, r}, 16'h0034);
    wr(4'd8, 8'h12); rd(4'd8, r); check("R3 year hi", {8'h0, r}, 16'h0012);
    wr(4'd9, 8'hFF); rd(4'd9, r); check("R3 year en", {8'h0, r}, 16'h0001);
    wr(4'd5, 8'h00); wr(4'd9, 8'h00);

    // vector table: R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      neutral();
      wr(4'd1, VECS[i].aSec);
      wr(4'd2, VECS[i].aMin);
      wr(4'd3, VECS[i].aHour);
      wr(4'd7, VECS[i].aYear[7:0]);
      wr(4'd8, VECS[i].aYear[15:8]);
      wr(4'd9, {7'h0, VECS[i].yen});
      wr(4'd0, 8'h08);
      settle({24'h0, VECS[i].nHour, VECS[i].nMin, VECS[i].nSec}, VECS[i].nYear);
      check($sformatf("R4/R5/R9 vector %0d", i), {15'h0, alarmIrq}, {15'h0, VECS[i].expIrq});
    end

    // R4: day of week, day and month fields
    wr(4'd1, 8'h00); wr(4'd2, 8'h00); wr(4'd3, 8'h00); wr(4'd9, 8'h00);
    neutral();
    wr(4'd4, 8'h83); wr(4'd5, 8'h97); wr(4'd6, 8'h91);
    wr(4'd0, 8'h08);
    settle({8'h11, 8'h17, 8'h03, 24'h0}, 16'h2000);
    check("R4 dow/day/month match", {15'h0, alarmIrq}, 16'h0001);

    // R7: enable gates the request; flag stays
    wr(4'd0, 8'h01); #1;
    check("R7 aie off", {15'h0, alarmIrq}, 16'h0000);
    rd(4'd0, r); check("R7 flag held", {8'h0, r}, 16'h0001);
    // R6: write 1 holds
    wr(4'd0, 8'h09); #1;
    check("R6 write 1 holds", {15'h0, alarmIrq}, 16'h0001);
    // R11: clear while matching stays clear
    wr(4'd0, 8'h08);
    repeat (3) @(negedge clk);
    check("R11 no reset while matching", {15'h0, alarmIrq}, 16'h0000);
    // R6: clear observed
    rd(4'd0, r); check("R6 cleared", {8'h0, r}, 16'h0008);
    // R11: re-entry sets again
    neutral();
    settle({8'h11, 8'h17, 8'h03, 24'h0}, 16'h2000);
    check("R11 re-entry sets", {15'h0, alarmIrq}, 16'h0001);

    // R10: clear and new match in same cycle
    neutral();
    @(negedge clk);
    timeNow = {8'h11, 8'h17, 8'h03, 24'h0};
    busAddr = 4'd0; busWrEn = 1'b1; busWrData = 8'h08;
    @(negedge clk);
    busWrEn = 1'b0;
    #1 check("R10 set wins", {15'h0, alarmIrq}, 16'h0001);

    // R9: all disabled, flag cleared stays clear
    wr(4'd4, 8'h03); wr(4'd5, 8'h17); wr(4'd6, 8'h11);
    wr(4'd0, 8'h08);
    neutral();
    settle({8'h11, 8'h17, 8'h03, 24'h0}, 16'h2000);
    check("R9 no enables", {15'h0, alarmIrq}, 16'h0000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule